// File: doc/BRIEF.md
# Parallel Camera Capture Interface

This block takes bytes from an external parallel source, such as a CMOS image sensor or a fast parallel ADC. The source supplies its own clock, an 8-bit data bus and two data-valid strobes. Sampling happens on the rising edge of the source clock. Qualified bytes are packed into an 8-, 16- or 32-bit word inside the source clock domain. Each finished word crosses into the system clock domain through a toggle synchronizer and lands in a read register. That register carries a ready flag and an overrun flag.

Two gating options shape which bytes are kept. The strobe option either requires both strobes high or ignores them. The decimation option keeps only every second qualifying byte, with the even or odd phase selected. This is how luminance is pulled out of an interleaved YUV422 stream.

The system side consumes a word by pulsing a read acknowledge. Configuration inputs are expected to change only while capture is disabled or between words.

Successive words must be at least four system clock cycles apart. Between them the finished word is held stable, so the system side can capture it.

Top module: `par_capture`

## Requirements
- R1: After reset, `rdy_o` and `ovr_o` are 0 and `rdata_o` is 0.
- R2: With `size_i` = 0 (8-bit), every kept byte becomes one word in `rdata_o[7:0]` with bits 31:8 zero. When the source clock edge falls between two system clock edges, `rdy_o` rises on the third system rising edge after it.
- R3: With `size_i` = 1 (16-bit), two kept bytes form one word. The first byte goes in bits 7:0 and the second in bits 15:8, with bits 31:16 zero. No word is delivered after the first byte alone.
- R4: With `size_i` = 2 (32-bit), four kept bytes form one word, with the first byte in bits 7:0 and the fourth in bits 31:24.
- R5: With `always_i` = 0, a byte qualifies only when `pen1_i` and `pen2_i` are both 1. A non-qualifying edge neither fills the word nor advances the decimation phase.
- R6: With `always_i` = 1, every source clock rising edge qualifies whatever the strobes are.
- R7: With `half_i` = 1 and `odd_i` = 0, qualifying bytes are numbered from 0 after enable, and only even-numbered bytes are kept.
- R8: With `half_i` = 1 and `odd_i` = 1, only odd-numbered qualifying bytes are kept.
- R9: A cycle with `rd_ack_i` = 1 and no arriving word clears `rdy_o` and `ovr_o`, and leaves `rdata_o` unchanged.
- R10: A word arriving while `rdy_o` = 1 and `rd_ack_i` = 0 sets `ovr_o`, and `rdata_o` takes the newer word.
- R11: A word arriving in the same cycle as `rd_ack_i` = 1 loads `rdata_o`, keeps `rdy_o` at 1 and leaves `ovr_o` at 0.
- R12: Deasserting `cap_en_i` discards a partly packed word and resets the decimation phase to byte 0.
- R13: While `cap_en_i` is 0, source clock edges deliver no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| pclk_i | input | 1 | Source clock |
| pdata_i | input | 8 | Source data byte |
| pen1_i | input | 1 | Source data strobe 1 |
| pen2_i | input | 1 | Source data strobe 2 |
| cap_en_i | input | 1 | Capture enable |
| size_i | input | 2 | Word size: 0 = 8, 1 = 16, 2 = 32 bits |
| always_i | input | 1 | 1 = ignore strobes |
| half_i | input | 1 | 1 = keep every second qualifying byte |
| odd_i | input | 1 | Decimation phase: 0 = even, 1 = odd |
| rd_ack_i | input | 1 | Read acknowledge pulse |
| rdata_o | output | 32 | Captured word |
| rdy_o | output | 1 | Word ready |
| ovr_o | output | 1 | Word overwritten before acknowledge |

## Verification
Word arrival from the synchronizer and the read acknowledge can land in the same system cycle. This decides whether the flags report an overrun or a clean hand-off.

The bench starts with an unread word pending. It raises the source clock midway between system edges, counts two system rising edges, and then holds `rd_ack_i` high across the third edge, which is the edge that loads the word.

It then expects the new word with `rdy_o` still set and no overrun. A separate case delivers the same word with no acknowledge, and there the overrun flag must be set.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic [1:0] {
    SZ_8  = 2'd0,
    SZ_16 = 2'd1,
    SZ_32 = 2'd2
  } size_e;

  // index of the last byte lane for a size code; code 3 behaves as 32-bit
  function automatic int unsigned last_lane(input logic [1:0] sz);
    case (sz)
      SZ_8:    return 0;
      SZ_16:   return 1;
      default: return 3;
    endcase
  endfunction
endpackage

// File: rtl/pc_sampler.sv
module pc_sampler #(
  parameter int unsigned DW = 8,
  parameter int unsigned NB = 4,
  localparam int unsigned CW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             pclk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DW-1:0]    pdata_i,
  input  logic             pen1_i,
  input  logic             pen2_i,
  input  logic [1:0]       size_i,
  input  logic             always_i,
  input  logic             half_i,
  input  logic             odd_i,
  output logic [DW*NB-1:0] word_o,
  output logic             req_o
);
  logic [1:0]               en_sync_q;
  logic                     en_s;
  logic [CW-1:0]            cnt_q;
  logic                     phase_q;
  logic [NB-1:0][DW-1:0]    acc_q, acc_nxt;
  logic [DW*NB-1:0]         hold_q;
  logic                     req_q;
  logic                     qual, keep, last;

  always_ff @(posedge pclk_i or negedge rst_ni)
    if (!rst_ni) en_sync_q <= '0;
    else         en_sync_q <= {en_sync_q[0], en_i};
  assign en_s = en_sync_q[1];

  assign qual = en_s && (always_i || (pen1_i && pen2_i));
  assign keep = qual && (!half_i || (phase_q == odd_i));
  assign last = (cnt_q == CW'(pc_pkg::last_lane(size_i)));

  always_comb begin
    acc_nxt = acc_q;
    acc_nxt[cnt_q] = pdata_i;
  end

  always_ff @(posedge pclk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
      acc_q   <= '0;
      hold_q  <= '0;
      req_q   <= 1'b0;
    end else if (!en_s) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
      acc_q   <= '0;
    end else begin
      if (qual) phase_q <= ~phase_q;
      if (keep) begin
        if (last) begin
          hold_q <= acc_nxt;
          req_q  <= ~req_q;
          acc_q  <= '0;
          cnt_q  <= '0;
        end else begin
          acc_q <= acc_nxt;
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end

  assign word_o = hold_q;
  assign req_o  = req_q;

  // R13
  no_cap_off_chk: assert property (@(posedge pclk_i) disable iff (!rst_ni)
    !en_s |=> $stable(req_q));
  // R4
  lane_range_chk: assert property (@(posedge pclk_i) disable iff (!rst_ni)
    en_s |-> (cnt_q <= CW'(pc_pkg::last_lane(size_i))));
  // R5
  gate_hold_chk: assert property (@(posedge pclk_i) disable iff (!rst_ni)
    (en_s && !always_i && !(pen1_i && pen2_i)) |=> ($stable(cnt_q) && $stable(phase_q)));
endmodule

// File: rtl/pc_tsync.sv
module pc_tsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic pulse_o
);
  logic [STAGES:0] sq;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sq <= '0;
    else         sq <= {sq[STAGES-1:0], req_i};

  assign pulse_o = sq[STAGES] ^ sq[STAGES-1];
endmodule

// File: rtl/pc_rdreg.sv
module pc_rdreg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         new_i,
  input  logic [W-1:0] word_i,
  input  logic         ack_i,
  output logic [W-1:0] rdata_o,
  output logic         rdy_o,
  output logic         ovr_o
);
  logic [W-1:0] rdata_q;
  logic         rdy_q, ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      rdata_q <= '0;
      rdy_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else if (new_i) begin
      rdata_q <= word_i;
      rdy_q   <= 1'b1;
      ovr_q   <= ack_i ? 1'b0 : (ovr_q | rdy_q);
    end else if (ack_i) begin
      rdy_q <= 1'b0;
      ovr_q <= 1'b0;
    end

  assign rdata_o = rdata_q;
  assign rdy_o   = rdy_q;
  assign ovr_o   = ovr_q;

  // R9
  ack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !new_i) |=> (!rdy_q && !ovr_q));
  // R9
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !new_i |=> $stable(rdata_q));
  // R10
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_i && rdy_q && !ack_i) |=> ovr_q);
  // R11
  collide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_i && ack_i) |=> (rdy_q && !ovr_q));
endmodule

// File: rtl/par_capture.sv
module par_capture #(
  parameter int unsigned DW          = 8,
  parameter int unsigned NB          = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned OW         = DW * NB
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pclk_i,
  input  logic [DW-1:0] pdata_i,
  input  logic          pen1_i,
  input  logic          pen2_i,
  input  logic          cap_en_i,
  input  logic [1:0]    size_i,
  input  logic          always_i,
  input  logic          half_i,
  input  logic          odd_i,
  input  logic          rd_ack_i,
  output logic [OW-1:0] rdata_o,
  output logic          rdy_o,
  output logic          ovr_o
);
  logic [OW-1:0] word;
  logic          req, new_word;

  pc_sampler #(.DW(DW), .NB(NB)) u_samp (
    .pclk_i  (pclk_i),
    .rst_ni  (rst_ni),
    .en_i    (cap_en_i),
    .pdata_i (pdata_i),
    .pen1_i  (pen1_i),
    .pen2_i  (pen2_i),
    .size_i  (size_i),
    .always_i(always_i),
    .half_i  (half_i),
    .odd_i   (odd_i),
    .word_o  (word),
    .req_o   (req)
  );

  pc_tsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .pulse_o(new_word)
  );

  pc_rdreg #(.W(OW)) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .new_i  (new_word),
    .word_i (word),
    .ack_i  (rd_ack_i),
    .rdata_o(rdata_o),
    .rdy_o  (rdy_o),
    .ovr_o  (ovr_o)
  );
endmodule

// File: tb/sim_par_capture.sv
module sim_par_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pclk = 1'b0;
  logic [7:0]  pdata = '0;
  logic        pen1 = 1'b0, pen2 = 1'b0;
  logic        cap_en = 1'b0;
  logic [1:0]  size = 2'd0;
  logic        alw = 1'b0, half = 1'b0, odd = 1'b0;
  logic        rd_ack = 1'b0;
  logic [31:0] rdata;
  logic        rdy, ovr;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  par_capture u0 (
    .clk_i(clk), .rst_ni(rst_n), .pclk_i(pclk), .pdata_i(pdata),
    .pen1_i(pen1), .pen2_i(pen2), .cap_en_i(cap_en), .size_i(size),
    .always_i(alw), .half_i(half), .odd_i(odd), .rd_ack_i(rd_ack),
    .rdata_o(rdata), .rdy_o(rdy), .ovr_o(ovr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [7:0] d, input logic e1, input logic e2);
    @(negedge clk);
    pdata = d; pen1 = e1; pen2 = e2;
    #5 pclk = 1'b1;
    @(negedge clk);
    #5 pclk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk); rd_ack = 1'b1;
    @(negedge clk); rd_ack = 1'b0;
  endtask

  task automatic stop();
    cap_en = 1'b0; alw = 1'b0;
    repeat (3) pulse(8'h00, 1'b0, 1'b0);
    ack();
  endtask

  task automatic start(input logic [1:0] sz, input logic a, input logic h, input logic o);
    alw = 1'b0; cap_en = 1'b1;
    repeat (3) pulse(8'h00, 1'b0, 1'b0);
    size = sz; alw = a; half = h; odd = o;
    ack();
  endtask

  task automatic t_reset();
    chk("R1 rdy", 32'(rdy), 32'd0);
    chk("R1 ovr", 32'(ovr), 32'd0);
    chk("R1 rdata", rdata, 32'd0);
  endtask

  task automatic t_size8();
    start(2'd0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    pdata = 8'hA5; pen1 = 1'b1; pen2 = 1'b1;
    #5 pclk = 1'b1;
    repeat (2) @(posedge clk);
    #5 chk("R2 not before 3rd edge", 32'(rdy), 32'd0);
    @(posedge clk);
    #5 chk("R2 rdy at 3rd edge", 32'(rdy), 32'd1);
    chk("R2 word", rdata, 32'h0000_00A5);
    pclk = 1'b0;
    repeat (3) @(negedge clk);
    ack();
    pulse(8'h3C, 1'b1, 1'b1);
    chk("R2 second word", rdata, 32'h0000_003C);
    stop();
  endtask

  task automatic t_size16();
    start(2'd1, 1'b0, 1'b0, 1'b0);
    pulse(8'h11, 1'b1, 1'b1);
    chk("R3 no word after one byte", 32'(rdy), 32'd0);
    pulse(8'h22, 1'b1, 1'b1);
    chk("R3 rdy", 32'(rdy), 32'd1);
    chk("R3 word", rdata, 32'h0000_2211);
    stop();
  endtask

  task automatic t_size32();
    start(2'd2, 1'b0, 1'b0, 1'b0);
    pulse(8'h01, 1'b1, 1'b1);
    pulse(8'h02, 1'b1, 1'b1);
    pulse(8'h03, 1'b1, 1'b1);
    chk("R4 no word after three bytes", 32'(rdy), 32'd0);
    pulse(8'h04, 1'b1, 1'b1);
    chk("R4 word", rdata, 32'h0403_0201);
    stop();
  endtask

  task automatic t_gate();
    start(2'd1, 1'b0, 1'b0, 1'b0);
    pulse(8'hAA, 1'b1, 1'b1);
    pulse(8'hE1, 1'b1, 1'b0);
    pulse(8'hE2, 1'b0, 1'b1);
    chk("R5 single strobe ignored", 32'(rdy), 32'd0);
    pulse(8'hBB, 1'b1, 1'b1);
    chk("R5 word", rdata, 32'h0000_BBAA);
    stop();
  endtask

  task automatic t_always();
    start(2'd1, 1'b1, 1'b0, 1'b0);
    pulse(8'h5A, 1'b0, 1'b0);
    pulse(8'hC3, 1'b1, 1'b0);
    chk("R6 strobes ignored", rdata, 32'h0000_C35A);
    stop();
  endtask

  task automatic t_half_even();
    start(2'd0, 1'b0, 1'b1, 1'b0);
    pulse(8'h10, 1'b1, 1'b1);
    chk("R7 byte 0 kept", rdata, 32'h10);
    ack();
    pulse(8'hFF, 1'b0, 1'b0);
    pulse(8'h11, 1'b1, 1'b1);
    chk("R7 byte 1 dropped", 32'(rdy), 32'd0);
    pulse(8'h12, 1'b1, 1'b1);
    chk("R7 byte 2 kept", rdata, 32'h12);
    stop();
  endtask

  task automatic t_half_odd();
    start(2'd0, 1'b0, 1'b1, 1'b1);
    pulse(8'h20, 1'b1, 1'b1);
    chk("R8 byte 0 dropped", 32'(rdy), 32'd0);
    pulse(8'h21, 1'b1, 1'b1);
    chk("R8 byte 1 kept", rdata, 32'h21);
    stop();
  endtask

  task automatic t_ack_ovr();
    start(2'd0, 1'b0, 1'b0, 1'b0);
    pulse(8'h31, 1'b1, 1'b1);
    pulse(8'h32, 1'b1, 1'b1);
    chk("R10 ovr set", 32'(ovr), 32'd1);
    chk("R10 newer word", rdata, 32'h32);
    ack();
    chk("R9 rdy cleared", 32'(rdy), 32'd0);
    chk("R9 ovr cleared", 32'(ovr), 32'd0);
    chk("R9 rdata held", rdata, 32'h32);
    stop();
  endtask

  task automatic t_collide();
    start(2'd0, 1'b0, 1'b0, 1'b0);
    pulse(8'h41, 1'b1, 1'b1);
    @(negedge clk);
    pdata = 8'h42; pen1 = 1'b1; pen2 = 1'b1;
    #5 pclk = 1'b1;
    repeat (2) @(posedge clk);
    #5 rd_ack = 1'b1;
    @(posedge clk);
    #5 rd_ack = 1'b0;
    chk("R11 rdy kept", 32'(rdy), 32'd1);
    chk("R11 no ovr", 32'(ovr), 32'd0);
    chk("R11 new word", rdata, 32'h42);
    pclk = 1'b0;
    repeat (3) @(negedge clk);
    stop();
  endtask

  task automatic t_disable();
    start(2'd1, 1'b0, 1'b0, 1'b0);
    pulse(8'h77, 1'b1, 1'b1);
    stop();
    pulse(8'h88, 1'b1, 1'b1);
    pulse(8'h99, 1'b1, 1'b1);
    chk("R13 no word while off", 32'(rdy), 32'd0);
    start(2'd1, 1'b0, 1'b0, 1'b0);
    pulse(8'h51, 1'b1, 1'b1);
    pulse(8'h52, 1'b1, 1'b1);
    chk("R12 partial discarded", rdata, 32'h0000_5251);
    stop();
    start(2'd0, 1'b0, 1'b1, 1'b0);
    pulse(8'h61, 1'b1, 1'b1);
    ack();
    stop();
    start(2'd0, 1'b0, 1'b1, 1'b0);
    pulse(8'h62, 1'b1, 1'b1);
    chk("R12 phase reset", 32'(rdy), 32'd1);
    chk("R12 phase reset word", rdata, 32'h62);
    stop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_size8();
    t_size16();
    t_size32();
    t_gate();
    t_always();
    t_half_even();
    t_half_odd();
    t_ack_ovr();
    t_collide();
    t_disable();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule